// File: doc/BRIEF.md
# Next-PC and Control-Flow Resolver

This block owns the program counter of a 32-bit, five-stage pipeline with 4-byte instructions. In each cycle it takes the instruction class, the operands and the PC of the control instruction being resolved. From these it picks the address the fetch stage uses next. With no transfer the fetch address steps forward by one instruction.

Three transfers are resolved. The first is a conditional branch that is taken when its two register operands differ. The second is an absolute jump that keeps the top four address bits of the jump instruction's own PC. The third is a jump to an address held in a register. Every taken transfer loads the new address into the PC and raises a flush pulse for one cycle, so the instructions fetched behind the transfer can be squashed. A stall input freezes the PC, but a transfer that resolves in the same cycle still wins.

Top module: `npc_resolver`

## Requirements
- R1: A synchronous active-high reset drives `pc_o` to 32'h00000000 and `flush_o` to 0 at the next rising edge.
- R2: With no taken transfer and `stall_i` low, `pc_o` grows by 4 at each rising edge.
- R3: Class code 2'd1 is the not-equal branch. When `op_a_i != op_b_i`, `pc_o` becomes `ctl_pc_i + 4 + (sign-extended off_i << 2)` at the next edge.
- R4: When a class 2'd1 branch has `op_a_i == op_b_i`, it causes no redirect and no flush, and the PC follows R2 or R8.
- R5: Class code 2'd2 is the absolute jump. `pc_o` becomes `{ctl_pc_i[31:28], jtgt_i, 2'b00}`.
- R6: Class code 2'd3 is the register jump. `pc_o` becomes `jreg_i` unchanged.
- R7: `flush_o` is high for exactly the cycle that follows each edge at which a transfer was taken, and low after every other edge. Class code 2'd0 is sequential and is never taken.
- R8: While `stall_i` is high and no transfer is taken, `pc_o` keeps its value.
- R9: A taken transfer updates `pc_o` even while `stall_i` is high.
- R10: `next_pc_o` shows, before the edge, the value that `pc_o` takes at that edge, as long as reset is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Holds the PC when no transfer is taken |
| kind_i | input | 2 | Instruction class: 0 sequential, 1 branch-if-not-equal, 2 jump, 3 jump-register |
| ctl_pc_i | input | 32 | PC of the control instruction being resolved |
| op_a_i | input | 32 | First branch comparison operand |
| op_b_i | input | 32 | Second branch comparison operand |
| off_i | input | 16 | Signed branch offset in words |
| jtgt_i | input | 26 | Jump target field |
| jreg_i | input | 32 | Register value used by the register jump |
| pc_o | output | 32 | Registered fetch PC |
| next_pc_o | output | 32 | Value the PC takes at the coming edge |
| flush_o | output | 1 | One-cycle squash request for younger instructions |

## Verification
`next_pc_o` is combinational, so it is checked in the same cycle that its inputs are driven. `pc_o` and `flush_o` both come out of one register stage and are due one edge after the stimulus. The driver applies each stimulus just after a falling edge and pushes the expected `pc_o` and `flush_o` for the coming rising edge. The monitor pops that entry at the next falling edge, which puts each comparison half a period after the register has updated. Cases that run back to back, such as a taken transfer followed directly by sequential flow, show that the flush pulse lasts a single cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN        = 32;
    localparam int OFF_W       = 16;
    localparam int JTGT_W      = 26;
    localparam int REGION_W    = XLEN - JTGT_W - 2;
    localparam int INSTR_BYTES = 4;
    localparam int WORD_SHIFT  = $clog2(INSTR_BYTES);

    typedef logic [XLEN-1:0] addr_t;

    typedef enum logic [1:0] {
        XK_SEQ  = 2'd0,
        XK_BNE  = 2'd1,
        XK_JMP  = 2'd2,
        XK_JREG = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic  take;
        addr_t target;
    } redirect_t;

    function automatic addr_t seq_pc(input addr_t pc);
        return pc + addr_t'(INSTR_BYTES);
    endfunction

    function automatic addr_t branch_pc(input addr_t pc, input logic [OFF_W-1:0] off);
        addr_t ext;
        ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        return seq_pc(pc) + (ext << WORD_SHIFT);
    endfunction

    function automatic addr_t region_pc(input addr_t pc, input logic [JTGT_W-1:0] tgt);
        return {pc[XLEN-1 -: REGION_W], tgt, {WORD_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_target_calc.sv
module npc_target_calc
    import npc_pkg::*;
(
    input  xfer_kind_e              kind_i,
    input  addr_t                   ctl_pc_i,
    input  addr_t                   op_a_i,
    input  addr_t                   op_b_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic [JTGT_W-1:0]       jtgt_i,
    input  addr_t                   jreg_i,
    output redirect_t               redir_o
);

    logic differ;
    assign differ = (op_a_i != op_b_i);

    always_comb begin
        redir_o = '0;
        unique case (kind_i)
            XK_BNE: begin
                redir_o.take   = differ;
                redir_o.target = branch_pc(ctl_pc_i, off_i);
            end
            XK_JMP: begin
                redir_o.take   = 1'b1;
                redir_o.target = region_pc(ctl_pc_i, jtgt_i);
            end
            XK_JREG: begin
                redir_o.take   = 1'b1;
                redir_o.target = jreg_i;
            end
            default: begin
                redir_o.take   = 1'b0;
                redir_o.target = ctl_pc_i;
            end
        endcase
    end

    // R4
    always_comb begin
        equal_bne_chk: assert (!(kind_i == XK_BNE && op_a_i == op_b_i) || !redir_o.take);
    end

    // R5
    always_comb begin
        jump_region_chk: assert (kind_i != XK_JMP ||
            (redir_o.target[XLEN-1 -: REGION_W] == ctl_pc_i[XLEN-1 -: REGION_W]));
    end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      stall_i,
    input  redirect_t redir_i,
    output addr_t     pc_o,
    output addr_t     next_pc_o,
    output logic      flush_o
);

    addr_t pc_q;
    logic  flush_q;

    always_comb begin
        if (redir_i.take)
            next_pc_o = redir_i.target;
        else if (stall_i)
            next_pc_o = pc_q;
        else
            next_pc_o = seq_pc(pc_q);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_q    <= RESET_PC;
            flush_q <= 1'b0;
        end else begin
            pc_q    <= next_pc_o;
            flush_q <= redir_i.take;
        end
    end

    assign pc_o    = pc_q;
    assign flush_o = flush_q;

    // R8
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_i && !redir_i.take) |=> $stable(pc_q));

    // R2
    seq_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && !redir_i.take) |=> (pc_q == $past(pc_q) + addr_t'(INSTR_BYTES)));

    // R9
    redirect_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        redir_i.take |=> (pc_q == $past(redir_i.target)));

    // R7
    flush_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !redir_i.take |=> !flush_q);

endmodule

// File: rtl/npc_resolver.sv
module npc_resolver
    import npc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        stall_i,
    input  logic [1:0]  kind_i,
    input  logic [31:0] ctl_pc_i,
    input  logic [31:0] op_a_i,
    input  logic [31:0] op_b_i,
    input  logic [15:0] off_i,
    input  logic [25:0] jtgt_i,
    input  logic [31:0] jreg_i,
    output logic [31:0] pc_o,
    output logic [31:0] next_pc_o,
    output logic        flush_o
);

    redirect_t redir;

    npc_target_calc u_calc (
        .kind_i   (xfer_kind_e'(kind_i)),
        .ctl_pc_i (ctl_pc_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .off_i    (off_i),
        .jtgt_i   (jtgt_i),
        .jreg_i   (jreg_i),
        .redir_o  (redir)
    );

    npc_pc_reg #(.RESET_PC('0)) u_pc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .stall_i   (stall_i),
        .redir_i   (redir),
        .pc_o      (pc_o),
        .next_pc_o (next_pc_o),
        .flush_o   (flush_o)
    );

    // R7
    taken_flush_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (kind_i != 2'd0 && (kind_i != 2'd1 || op_a_i != op_b_i)) |=> flush_o);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (pc_o == 32'h0 && !flush_o));

endmodule

// File: tb/test_npc_resolver.sv
module test_npc_resolver;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [31:0] ctl_pc = '0, op_a = '0, op_b = '0, jreg = '0;
    logic [15:0] off = '0;
    logic [25:0] jtgt = '0;
    logic [31:0] pc_o, next_pc_o;
    logic        flush_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_resolver i_npc_resolver (
        .clk_i(clk), .rst_i(rst), .stall_i(stall), .kind_i(kind),
        .ctl_pc_i(ctl_pc), .op_a_i(op_a), .op_b_i(op_b), .off_i(off),
        .jtgt_i(jtgt), .jreg_i(jreg),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .flush_o(flush_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic        flush;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cycles = 0;
    logic [31:0] model_pc = '0;

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
            report();
        end
    end

    // monitor: one edge after each stimulus, half a period past the edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (pc_o !== e.pc || flush_o !== e.flush) begin
                n_bad++;
                $display("FAIL %s: actual pc=%h flush=%b expected pc=%h flush=%b",
                         e.tag, pc_o, flush_o, e.pc, e.flush);
            end
        end
    end

    task automatic step(input logic r, input logic st, input logic [1:0] k,
                        input logic [31:0] cpc, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] o, input logic [25:0] t, input logic [31:0] jr,
                        input string tag);
        logic        take;
        logic [31:0] tgt, nxt;
        exp_t        e;
        @(negedge clk);
        #1;
        rst = r; stall = st; kind = k; ctl_pc = cpc; op_a = a; op_b = b;
        off = o; jtgt = t; jreg = jr;
        take = 1'b0;
        tgt  = '0;
        case (k)
            2'd1: begin take = (a != b); tgt = cpc + 32'd4 + {{14{o[15]}}, o, 2'b00}; end
            2'd2: begin take = 1'b1; tgt = {cpc[31:28], t, 2'b00}; end
            2'd3: begin take = 1'b1; tgt = jr; end
            default: ;
        endcase
        nxt = take ? tgt : (st ? model_pc : model_pc + 32'd4);
        if (!r) begin
            #1;
            n_chk++;
            if (next_pc_o !== nxt) begin
                n_bad++;
                $display("FAIL R10 %s: actual next_pc=%h expected %h", tag, next_pc_o, nxt);
            end
        end
        model_pc = r ? 32'h0 : nxt;
        e.pc    = model_pc;
        e.flush = r ? 1'b0 : take;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    initial begin
        // R1: reset state
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        // R2: sequential flow
        repeat (3) step(0, 0, 0, 32'h55, 1, 2, 0, 0, 0, "R2 sequential");
        // R8: stall holds
        repeat (2) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 stall hold");
        // R3: taken branch, positive offset
        step(0, 0, 1, 32'h100, 32'd7, 32'd9, 16'd5, 0, 0, "R3 bne forward");
        // R7: flush drops after one cycle
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 flush single cycle");
        // R3: negative offset
        step(0, 0, 1, 32'h200, 32'hFFFF_FFFF, 32'h0, 16'hFFFE, 0, 0, "R3 bne backward");
        // R4: equal operands, no redirect
        step(0, 0, 1, 32'h4000, 32'hABCD, 32'hABCD, 16'h0010, 0, 0, "R4 bne equal");
        // R4 with stall: hold and no flush
        step(0, 1, 1, 32'h4000, 32'h1, 32'h1, 16'h0010, 0, 0, "R4 bne equal stalled");
        // R5: region jump
        step(0, 0, 2, 32'hA000_0010, 0, 0, 0, 26'h0000040, 0, "R5 jump");
        step(0, 0, 2, 32'h7FFF_FFFC, 0, 0, 0, 26'h3FFFFFF, 0, "R5 jump max field");
        // R6: register jump
        step(0, 0, 3, 32'h10, 0, 0, 0, 0, 32'h1234_5678, "R6 jump register");
        // R9: transfer wins over stall
        step(0, 1, 2, 32'hC000_0000, 0, 0, 0, 26'h0000123, 0, "R9 jump under stall");
        step(0, 1, 3, 0, 0, 0, 0, 0, 32'h0000_0800, "R9 jr under stall");
        // R7: back-to-back transfers each flush
        step(0, 0, 1, 32'h300, 32'd1, 32'd2, 16'h8000, 0, 0, "R7 bne min offset");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 after transfer");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 stall after transfer");
        // R1: reset mid-run
        step(1, 0, 3, 0, 0, 0, 0, 0, 32'hFFFF_0000, "R1 reset beats transfer");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 resume after reset");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
        repeat (2) @(negedge clk);
        #2;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual pending=%0d expected 0", sb.size());
        end
        report();
    end

endmodule